// File: doc/BRIEF.md
# Dual-Port Shared Memory with Address-Collision Busy and Mailbox Interrupts

This block is a synchronous two-port memory. Each side (left and right) has its own address, write data, read data, chip enable, write enable and output enable. Either side can read or write any word in any cycle. The two ports share one array of `2**ADDR_W` words of `DATA_W` bits. A deployment sets `ADDR_W = 13` (8192 words) and `DATA_W` to 8 or 9. The defaults are kept small.

When both ports select the same word in one cycle and at least one of them writes, a collision arbiter picks a winner. It raises a busy flag, in the same cycle, to the port that lost, and it suppresses that port's write. A mode strap `is_master` chooses where busy comes from. When the strap is high, busy comes from the internal arbiter. When it is low, busy is taken from the `*_busy_i` inputs, which are driven by a master device elsewhere. This lets several devices share one arbitration decision for wider words.

The two highest words double as mailboxes. Each one drives a push-pull interrupt flag to the opposite port.

Top module: `dpram_arb_top`

## Requirements
- R1: A port with chip enable and write enable high and busy low stores its data at its address on the clock edge. A read request (chip enable high, output enable high, write enable low) returns the word on that port's `*_dout` after the following clock edge, one cycle of latency. The value returned is the word as it was before any write in the same cycle.
- R2: `*_dout` is zero in a cycle unless that port made a read request in the previous cycle. Output enable low, chip enable low or a write all give zero.
- R3: Two reads of the same word in the same cycle raise no busy flag, and both ports receive the data.
- R4: In master mode, a fresh collision goes to the left port. A fresh collision means both ports are enabled on the same address, at least one is writing, and neither port already holds the word. In that cycle `r_busy_o` is 1 and `l_busy_o` is 0, both combinational from the current inputs.
- R5: A port holds a word when it accessed that address in the previous cycle and the other port did not. If the right port holds the word when the left port arrives, the right port wins: `l_busy_o` is 1 and `r_busy_o` is 0. While a collision continues on the same address in consecutive cycles, the winner does not change.
- R6: In master mode, busy is raised only on a collision, and never on both ports at once.
- R7: A write from a port whose effective busy is 1 is dropped, and the word keeps its old value. The busy port's read still happens.
- R8: In slave mode (`is_master` = 0), each `*_busy_o` equals its `*_busy_i`. A port with `*_busy_i` = 1 has its write dropped, and the internal arbiter has no effect.
- R9: Writes from both ports to different words in the same cycle both take effect. If two unblocked writes hit the same word, which can only happen in slave mode, the left data is kept.
- R10: A completed left write to the highest address `2**ADDR_W-1` sets `r_int` after that edge. A right access to that address with chip enable high and write enable low clears `r_int`. If set and clear fall in the same cycle, set wins.
- R11: A completed right write to address `2**ADDR_W-2` sets `l_int`. A left access to that address with chip enable high and write enable low clears `l_int`. If set and clear fall in the same cycle, set wins.
- R12: During and after reset (`rst_n` low, active-low), both `*_dout`, both interrupts and the arbiter's access history are zero. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master | input | 1 | 1: internal arbiter drives busy; 0: busy taken from inputs |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write enable, active high |
| l_oe | input | 1 | Left output enable, active high |
| l_addr | input | ADDR_W | Left word address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data, zero when idle |
| l_busy_i | input | 1 | Left busy from a master device (slave mode) |
| l_busy_o | output | 1 | Left effective busy |
| l_int | output | 1 | Left mailbox interrupt |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write enable, active high |
| r_oe | input | 1 | Right output enable, active high |
| r_addr | input | ADDR_W | Right word address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data, zero when idle |
| r_busy_i | input | 1 | Right busy from a master device (slave mode) |
| r_busy_o | output | 1 | Right effective busy |
| r_int | output | 1 | Right mailbox interrupt |

## Verification
The busy flags are combinational, so they are due in the same cycle as the addresses that cause them. The bench drives inputs on the falling edge and compares busy one time unit later, well before the next rising edge. Read data and both interrupts are registered and appear one rising edge after the request. The bench updates its own model of the memory, the arbiter history and the flags at each rising edge. It compares those values at the next falling edge, before new inputs are applied.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;

  // A collision needs both ports enabled on one word with at least one writer.
  function automatic logic f_collide(input logic ce_a, input logic ce_b,
                                     input logic same, input logic we_a,
                                     input logic we_b);
    return ce_a && ce_b && same && (we_a || we_b);
  endfunction

  // Right wins a continuing collision if it won before, otherwise if it holds the word.
  function automatic logic f_right_wins(input logic cont, input logic win_r_q,
                                        input logic r_holds);
    return cont ? win_r_q : r_holds;
  endfunction

  // Flag update: set has priority over clear.
  function automatic logic f_flag_next(input logic cur, input logic set,
                                       input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              arb_busy_l,
  output logic              arb_busy_r,
  output logic              collide
);
  import dpram_arb_pkg::*;

  logic              lq_ce, rq_ce, col_q, win_r_q;
  logic [ADDR_W-1:0] lq_addr, rq_addr;
  logic              same_addr, cont, r_holds, win_r;

  assign same_addr = (l_addr == r_addr);
  assign collide   = f_collide(l_ce, r_ce, same_addr, l_we, r_we);
  assign cont      = col_q && (lq_addr == l_addr);
  assign r_holds   = rq_ce && (rq_addr == r_addr) && !(lq_ce && (lq_addr == l_addr));
  assign win_r     = f_right_wins(cont, win_r_q, r_holds);

  assign arb_busy_r = collide && !win_r;
  assign arb_busy_l = collide && win_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lq_ce   <= 1'b0;
      rq_ce   <= 1'b0;
      lq_addr <= '0;
      rq_addr <= '0;
      col_q   <= 1'b0;
      win_r_q <= 1'b0;
    end else begin
      lq_ce   <= l_ce;
      rq_ce   <= r_ce;
      lq_addr <= l_addr;
      rq_addr <= r_addr;
      col_q   <= collide;
      win_r_q <= win_r;
    end
  end

  // R6: never both ports busy
  a_r6_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_busy_l && arb_busy_r));

  // R3: shared reads never stall
  a_r3_shared_read: assert property (@(posedge clk) disable iff (!rst_n)
    (l_ce && r_ce && !l_we && !r_we) |-> (!arb_busy_l && !arb_busy_r));

  // R5: a continuing collision keeps its winner
  a_r5_keep_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && cont) |-> (arb_busy_r == $past(arb_busy_r)));

endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_din,
  input  logic              l_blk,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_din,
  input  logic              r_blk,
  output logic [DATA_W-1:0] l_dout,
  output logic [DATA_W-1:0] r_dout,
  output logic              l_wr_fire,
  output logic              r_wr_fire
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              l_rd_req, r_rd_req;

  assign l_wr_fire = l_ce && l_we && !l_blk;
  assign r_wr_fire = r_ce && r_we && !r_blk;
  assign l_rd_req  = l_ce && l_oe && !l_we;
  assign r_rd_req  = r_ce && r_oe && !r_we;

  // The left write is issued last, so it wins a same-word tie.
  always_ff @(posedge clk) begin
    if (r_wr_fire) mem[r_addr] <= r_din;
    if (l_wr_fire) mem[l_addr] <= l_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_dout <= '0;
      r_dout <= '0;
    end else begin
      l_dout <= l_rd_req ? mem[l_addr] : '0;
      r_dout <= r_rd_req ? mem[r_addr] : '0;
    end
  end

  // R2: idle ports return zero
  a_r2_left_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(l_ce && l_oe && !l_we) |-> (l_dout == '0));
  a_r2_right_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(r_ce && r_oe && !r_we) |-> (r_dout == '0));

endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr_fire,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_wr_fire,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_int,
  output logic              r_int
);
  import dpram_arb_pkg::*;

  localparam logic [ADDR_W-1:0] BOX_TO_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

  logic set_r, clr_r, set_l, clr_l;

  assign set_r = l_wr_fire && (l_addr == BOX_TO_R);
  assign clr_r = r_ce && !r_we && (r_addr == BOX_TO_R);
  assign set_l = r_wr_fire && (r_addr == BOX_TO_L);
  assign clr_l = l_ce && !l_we && (l_addr == BOX_TO_L);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_int <= 1'b0;
      r_int <= 1'b0;
    end else begin
      r_int <= f_flag_next(r_int, set_r, clr_r);
      l_int <= f_flag_next(l_int, set_l, clr_l);
    end
  end

  // R10: right interrupt rises only after a completed left write to its box
  a_r10_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_int) |-> $past(l_wr_fire && (l_addr == BOX_TO_R)));
  a_r10_fall_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_int) |-> $past(r_ce && !r_we && (r_addr == BOX_TO_R)));
  // R11: left interrupt mirrors it
  a_r11_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_int) |-> $past(r_wr_fire && (r_addr == BOX_TO_L)));
  a_r11_fall_src: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_int) |-> $past(l_ce && !l_we && (l_addr == BOX_TO_L)));

endmodule

// File: rtl/dpram_arb_top.sv
module dpram_arb_top #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_master,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_din,
  output logic [DATA_W-1:0] l_dout,
  input  logic              l_busy_i,
  output logic              l_busy_o,
  output logic              l_int,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_din,
  output logic [DATA_W-1:0] r_dout,
  input  logic              r_busy_i,
  output logic              r_busy_o,
  output logic              r_int
);
  logic arb_busy_l, arb_busy_r, collide;
  logic l_wr_fire, r_wr_fire;

  dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
    .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
    .arb_busy_l(arb_busy_l), .arb_busy_r(arb_busy_r), .collide(collide)
  );

  assign l_busy_o = is_master ? arb_busy_l : l_busy_i;
  assign r_busy_o = is_master ? arb_busy_r : r_busy_i;

  dpram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_din(l_din), .l_blk(l_busy_o),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_din(r_din), .r_blk(r_busy_o),
    .l_dout(l_dout), .r_dout(r_dout), .l_wr_fire(l_wr_fire), .r_wr_fire(r_wr_fire)
  );

  dpram_mailbox #(.ADDR_W(ADDR_W)) u_mbox (
    .clk(clk), .rst_n(rst_n),
    .l_wr_fire(l_wr_fire), .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
    .r_wr_fire(r_wr_fire), .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
    .l_int(l_int), .r_int(r_int)
  );

  // R6: master-mode busy only on a collision
  a_r6_busy_needs_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && (l_busy_o || r_busy_o)) |-> collide);
  // R7: a busy port never writes
  a_r7_left_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    l_busy_o |-> !l_wr_fire);
  a_r7_right_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    r_busy_o |-> !r_wr_fire);
  // R8: slave-mode busy input blocks the local write
  a_r8_slave_block: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && r_busy_i) |-> !r_wr_fire);

endmodule

// File: tb/dpram_arb_tb.sv
module dpram_arb_top_tb_top;
  localparam int AW = 8;
  localparam int DW = 9;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP = {AW{1'b1}};
  localparam logic [AW-1:0] TOP_M1 = TOP - 1'b1;

  logic clk = 1'b0, rst_n = 1'b0, is_master = 1'b1;
  logic l_ce = 0, l_we = 0, l_oe = 0, l_busy_i = 0;
  logic r_ce = 0, r_we = 0, r_oe = 0, r_busy_i = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_din = '0, r_din = '0;
  logic [DW-1:0] l_dout, r_dout;
  logic l_busy_o, r_busy_o, l_int, r_int;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_arb_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .is_master(is_master),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_din(l_din),
    .l_dout(l_dout), .l_busy_i(l_busy_i), .l_busy_o(l_busy_o), .l_int(l_int),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_din(r_din),
    .r_dout(r_dout), .r_busy_i(r_busy_i), .r_busy_o(r_busy_o), .r_int(r_int)
  );

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] e_ldout = '0, e_rdout = '0;
  logic e_lint = 0, e_rint = 0;
  logic p_lce = 0, p_rce = 0, p_col = 0, p_winr = 0;
  logic [AW-1:0] p_la = '0, p_ra = '0;
  logic m_bl, m_br, m_col, m_winr;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bench view of the arbitration rules (R4, R5, R8).
  function automatic void model_busy();
    logic cont, rh, arb_l, arb_r;
    m_col  = l_ce && r_ce && (l_addr == r_addr) && (l_we || r_we);
    cont   = p_col && (p_la == l_addr);
    rh     = p_rce && (p_ra == r_addr) && !(p_lce && (p_la == l_addr));
    m_winr = cont ? p_winr : rh;
    arb_r  = m_col && !m_winr;
    arb_l  = m_col && m_winr;
    m_bl   = is_master ? arb_l : l_busy_i;
    m_br   = is_master ? arb_r : r_busy_i;
  endfunction

  function automatic void model_edge();
    logic lw, rw;
    lw = l_ce && l_we && !m_bl;
    rw = r_ce && r_we && !m_br;
    e_ldout = (l_ce && l_oe && !l_we) ? m_mem[l_addr] : '0;
    e_rdout = (r_ce && r_oe && !r_we) ? m_mem[r_addr] : '0;
    if (lw && l_addr == TOP) e_rint = 1'b1;
    else if (r_ce && !r_we && r_addr == TOP) e_rint = 1'b0;
    if (rw && r_addr == TOP_M1) e_lint = 1'b1;
    else if (l_ce && !l_we && l_addr == TOP_M1) e_lint = 1'b0;
    if (rw) m_mem[r_addr] = r_din;
    if (lw) m_mem[l_addr] = l_din;
    p_lce = l_ce; p_rce = r_ce; p_la = l_addr; p_ra = r_addr;
    p_col = m_col; p_winr = m_winr;
  endfunction

  task automatic step(input logic lce, lwe, loe, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                      input logic rce, rwe, roe, input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                      input logic mst, bli, bri);
    @(negedge clk);
    chk(l_dout, e_ldout, "R1 left read data");
    chk(r_dout, e_rdout, "R1 right read data");
    chk(r_int, e_rint, "R10 right interrupt");
    chk(l_int, e_lint, "R11 left interrupt");
    l_ce = lce; l_we = lwe; l_oe = loe; l_addr = la; l_din = ld;
    r_ce = rce; r_we = rwe; r_oe = roe; r_addr = ra; r_din = rd;
    is_master = mst; l_busy_i = bli; r_busy_i = bri;
    #1;
    model_busy();
    chk(l_busy_o, m_bl, "R4 left busy");
    chk(r_busy_o, m_br, "R4 right busy");
    @(posedge clk);
    model_edge();
  endtask

  task automatic idle();
    step(0,0,0,'0,'0, 0,0,0,'0,'0, 1,0,0);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(l_dout, 0, "R12 reset left dout");
    chk(r_dout, 0, "R12 reset right dout");
    chk({l_int, r_int}, 0, "R12 reset interrupts");
    rst_n = 1'b1;

    // Preload words 0..7 and both mailboxes on separate addresses (R9).
    for (int a = 0; a < 8; a += 2)
      step(1,1,0,AW'(a),DW'(a+16), 1,1,0,AW'(a+1),DW'(a+17), 1,0,0);
    step(1,1,0,TOP,9'h1A5, 1,1,0,TOP_M1,9'h05A, 1,0,0);
    #2;
    chk(r_int, 1, "R10 set by left write to top");
    chk(l_int, 1, "R11 set by right write to top-1");
    // Shared read (R3).
    step(1,0,1,AW'(3),'0, 1,0,1,AW'(3),'0, 1,0,0);
    chk({l_busy_o, r_busy_o}, 0, "R3 no busy on shared read");
    #2;
    chk(l_dout, 19, "R3 left shared read");
    chk(r_dout, 19, "R3 right shared read");
    // Fresh collision: left wins, right write dropped (R4, R7).
    idle();
    step(1,1,0,AW'(5),9'h111, 1,1,0,AW'(5),9'h022, 1,0,0);
    idle();
    step(1,0,1,AW'(5),'0, 0,0,0,'0,'0, 1,0,0);
    #2;
    chk(l_dout, 9'h111, "R7 busy right write dropped");
    // Right holds the word, left arrives (R5).
    idle();
    step(0,0,0,'0,'0, 1,0,1,AW'(6),'0, 1,0,0);
    step(1,1,0,AW'(6),9'h0AA, 1,0,1,AW'(6),'0, 1,0,0);
    chk({l_busy_o, r_busy_o}, 2'b10, "R5 holder keeps priority");
    step(1,1,0,AW'(6),9'h0AB, 1,1,0,AW'(6),9'h0CC, 1,0,0);
    chk({l_busy_o, r_busy_o}, 2'b10, "R5 winner kept while collision continues");
    // Mailbox clears (R10, R11) with reads.
    step(1,0,1,TOP_M1,'0, 1,0,1,TOP,'0, 1,0,0);
    #2;
    chk({l_int, r_int}, 0, "R10 R11 cleared by reads");
    chk(r_dout, 9'h1A5, "R10 mailbox data");
    // Slave mode: busy in blocks writes, no arbitration (R8, R9).
    step(1,1,0,AW'(7),9'h155, 1,1,0,AW'(7),9'h0EE, 0,0,0);
    chk({l_busy_o, r_busy_o}, 0, "R8 slave ignores arbiter");
    step(1,0,1,AW'(7),'0, 1,1,0,AW'(2),9'h077, 0,0,1);
    chk(r_busy_o, 1, "R8 busy out follows busy in");
    #2;
    chk(l_dout, 9'h155, "R9 same-word tie keeps left");
    step(1,0,1,AW'(2),'0, 0,0,0,'0,'0, 1,0,0);
    #2;
    chk(l_dout, 18, "R8 blocked slave write left word");
    // Output enable low gives zero (R2).
    step(1,0,0,AW'(1),'0, 1,0,1,AW'(1),'0, 1,0,0);
    #2;
    chk(l_dout, 0, "R2 output enable low");
    chk(r_dout, 17, "R2 right still reads");
    // Set beats clear (R10).
    step(1,1,0,TOP,9'h033, 1,0,1,TOP,'0, 1,0,0);
    #2;
    chk(r_int, 1, "R10 set wins over clear");

    // Constrained random traffic on a small pool of addresses.
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] la, ra;
      logic mst;
      case ($urandom_range(0,5))
        0: la = TOP; 1: la = TOP_M1; default: la = AW'($urandom_range(0,3));
      endcase
      case ($urandom_range(0,5))
        0: ra = TOP; 1: ra = TOP_M1; default: ra = AW'($urandom_range(0,3));
      endcase
      mst = ($urandom_range(0,3) != 0);
      step($urandom_range(0,4) != 0, $urandom_range(0,1) == 1, $urandom_range(0,3) != 0, la, DW'($urandom),
           $urandom_range(0,4) != 0, $urandom_range(0,1) == 1, $urandom_range(0,3) != 0, ra, DW'($urandom),
           mst, $urandom_range(0,3) == 0, $urandom_range(0,3) == 0);
    end
    idle();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule